// File: doc/BRIEF.md
# Multi-format serial audio deserializer

The block receives two's-complement stereo samples sent most significant bit first on a serial data line. A left/right clock frames each sample and a bit clock shifts in the data. Every input is sampled in the system clock domain. The bit clock comes either from a device pin or from an on-chip generator, and a select input chooses between them. Each channel has its own parallel output word and a one-cycle valid strobe. Over one left/right clock period the block delivers one left word and one right word.

Run-time inputs set the framing, the word length and the sampling edge. The framing is left-justified, right-justified or I2S; I2S takes priority over the right-justify setting. The word length is 18 or 16 bits, and 16-bit words are sign-extended to the full output width. The falling-edge option applies only when the pin clock is selected. Each mode input is expected to stay constant while frames are flowing.

Top module: `audio_deser`

## Requirements
- R1: While rst_ni is low, both output words read zero and both valid strobes are low.
- R2: Data and the left/right clock are sampled on the rising edge of the selected bit clock (bclk_pin_i when use_pin_i=1, otherwise bclk_gen_i). The falling edge is used instead only when fall_edge_i=1 and use_pin_i=1. With the generated clock, fall_edge_i has no effect.
- R3: Left-justified framing (right_just_i=0, i2s_i=0): the bit sampled on the first edge at the new left/right clock level is the MSB. The word is complete after N bits. A left/right clock level of 1 marks the left channel.
- R4: I2S framing (i2s_i=1, whatever right_just_i is set to): the first sampling edge after a left/right clock change is skipped and the next N bits form the word. A left/right clock level of 0 marks the left channel.
- R5: Right-justified framing (right_just_i=1, i2s_i=0): the word is the last N bits sampled before the left/right clock change, and earlier bits are discarded. It is delivered on the edge that sees the change. If that period held fewer than N sampled bits, no word is delivered.
- R6: N is 16 when word16_i=1 and 18 otherwise. For a 16-bit word, bits 17:16 of the output copy bit 15.
- R7: Each completed word raises the valid strobe of its channel for exactly one system clock. The two strobes are never high together, and each output word holds its value between strobes.
- R8: After reset, no word is delivered until the first change of the left/right clock has been sampled.
- R9: The strobe and the word appear one system clock after the rising system clock edge at which the selected bit clock is first seen at its sampling level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_pin_i | input | 1 | Bit clock from a pin |
| bclk_gen_i | input | 1 | Bit clock from the internal generator |
| use_pin_i | input | 1 | 1 selects bclk_pin_i |
| fall_edge_i | input | 1 | Sample on the falling edge (pin clock only) |
| lrck_i | input | 1 | Left/right framing clock |
| sdata_i | input | 1 | Serial data, MSB first |
| right_just_i | input | 1 | 1 selects right-justified framing |
| i2s_i | input | 1 | 1 selects I2S framing |
| word16_i | input | 1 | 1 selects 16-bit words, 0 selects 18-bit words |
| left_o | output | 18 | Left word |
| left_vld_o | output | 1 | Left word strobe |
| right_o | output | 18 | Right word |
| right_vld_o | output | 1 | Right word strobe |

## Verification
A word is due exactly one system clock after the rising clock edge that first sees the sampling bit-clock level, and the strobe goes low on the clock after that. A directed test drives that bit-clock edge on a falling system clock edge. It then checks the strobe and the word on the next falling edge and checks the strobe low one falling edge later. In the other tests, a monitor on the falling edge records the strobes: the number of pulses per channel and the first word. These are compared only after a full frame and a trailing bit. In right-justified mode that trailing bit is the edge on which the right word is released.

// File: rtl/audio_deser_pkg.sv
package audio_deser_pkg;

  typedef struct packed {
    logic rj;
    logic i2s;
    logic w16;
  } cfg_t;

  // LRCK level that marks the left channel
  function automatic logic left_level(input logic i2s);
    return !i2s;
  endfunction

endpackage

// File: rtl/audio_deser_bclk_edge.sv
module audio_deser_bclk_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_pin_i,
  input  logic bclk_gen_i,
  input  logic use_pin_i,
  input  logic fall_edge_i,
  output logic smp_o
);
  logic bclk_sel, bclk_q, use_fall;

  assign bclk_sel = use_pin_i ? bclk_pin_i : bclk_gen_i;
  assign use_fall = use_pin_i & fall_edge_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_q <= 1'b0;
    else         bclk_q <= bclk_sel;
  end

  assign smp_o = use_fall ? (bclk_q & ~bclk_sel) : (~bclk_q & bclk_sel);
endmodule

// File: rtl/audio_deser_frame_track.sv
module audio_deser_frame_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_i,
  input  logic lrck_i,
  output logic lr_o,
  output logic trans_o,
  output logic synced_o
);
  logic primed_q, lr_q, synced_q;

  assign trans_o  = smp_i & primed_q & (lrck_i != lr_q);
  assign lr_o     = lr_q;
  assign synced_o = synced_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
      lr_q     <= 1'b0;
      synced_q <= 1'b0;
    end else if (smp_i) begin
      primed_q <= 1'b1;
      lr_q     <= lrck_i;
      if (trans_o) synced_q <= 1'b1;
    end
  end
endmodule

// File: rtl/audio_deser_shift_core.sv
module audio_deser_shift_core
  import audio_deser_pkg::*;
#(
  parameter int W_MAX = 18,
  parameter int W_MIN = 16,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_i,
  input  logic             trans_i,
  input  logic             synced_i,
  input  logic             lr_i,
  input  logic             sdata_i,
  input  cfg_t             cfg_i,
  output logic             word_vld_o,
  output logic             word_left_o,
  output logic [W_MAX-1:0] word_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LEN_L   = CNT_W'(W_MAX);
  localparam logic [CNT_W-1:0] LEN_S   = CNT_W'(W_MIN);

  logic [W_MAX-1:0] sh_q, sh_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, len;
  logic             rj_eff, done_rj, done_j;

  assign rj_eff  = cfg_i.rj & ~cfg_i.i2s;
  assign len     = cfg_i.w16 ? LEN_S : LEN_L;
  assign sh_nxt  = {sh_q[W_MAX-2:0], sdata_i};
  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (trans_i)               cnt_d = cfg_i.i2s ? '0 : CNT_W'(1);
    else if (cnt_q != CNT_MAX) cnt_d = cnt_inc;
  end

  // right-justified: release the tail of the closing period on the change
  assign done_rj = smp_i & rj_eff & trans_i & synced_i & (cnt_q >= len);
  // justified formats: release once N bits of the current period are in
  assign done_j  = smp_i & ~rj_eff & ~trans_i & synced_i & (cnt_inc == len);

  assign word_vld_o  = done_rj | done_j;
  assign word_o      = done_rj ? sh_q : sh_nxt;
  assign word_left_o = (lr_i == left_level(cfg_i.i2s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (smp_i) begin
      sh_q  <= sh_nxt;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/audio_deser_out_stage.sv
module audio_deser_out_stage
  import audio_deser_pkg::*;
#(
  parameter int W_MAX = 18,
  parameter int W_MIN = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             left_i,
  input  logic [W_MAX-1:0] word_i,
  input  cfg_t             cfg_i,
  output logic [W_MAX-1:0] word_o [2],
  output logic [1:0]       vld_o
);
  localparam int EXT = W_MAX - W_MIN;

  logic [W_MAX-1:0] ext_word;

  assign ext_word = cfg_i.w16 ? {{EXT{word_i[W_MIN-1]}}, word_i[W_MIN-1:0]} : word_i;

  // channel 0 = left, channel 1 = right
  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic hit;
    assign hit = vld_i & (left_i == (c == 0));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_o[c] <= '0;
        vld_o[c]  <= 1'b0;
      end else begin
        vld_o[c] <= hit;
        if (hit) word_o[c] <= ext_word;
      end
    end
  end
endmodule

// File: rtl/audio_deser.sv
module audio_deser
  import audio_deser_pkg::*;
#(
  parameter int W_MAX = 18,
  parameter int W_MIN = 16,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bclk_pin_i,
  input  logic             bclk_gen_i,
  input  logic             use_pin_i,
  input  logic             fall_edge_i,
  input  logic             lrck_i,
  input  logic             sdata_i,
  input  logic             right_just_i,
  input  logic             i2s_i,
  input  logic             word16_i,
  output logic [W_MAX-1:0] left_o,
  output logic             left_vld_o,
  output logic [W_MAX-1:0] right_o,
  output logic             right_vld_o
);
  cfg_t             cfg;
  logic             smp, trans, synced, lr;
  logic             w_vld, w_left;
  logic [W_MAX-1:0] w_data;
  logic [W_MAX-1:0] ch_word [2];
  logic [1:0]       ch_vld;

  assign cfg = '{rj: right_just_i, i2s: i2s_i, w16: word16_i};

  audio_deser_bclk_edge u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bclk_pin_i  (bclk_pin_i),
    .bclk_gen_i  (bclk_gen_i),
    .use_pin_i   (use_pin_i),
    .fall_edge_i (fall_edge_i),
    .smp_o       (smp)
  );

  audio_deser_frame_track u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .smp_i    (smp),
    .lrck_i   (lrck_i),
    .lr_o     (lr),
    .trans_o  (trans),
    .synced_o (synced)
  );

  audio_deser_shift_core #(
    .W_MAX (W_MAX),
    .W_MIN (W_MIN),
    .CNT_W (CNT_W)
  ) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .smp_i       (smp),
    .trans_i     (trans),
    .synced_i    (synced),
    .lr_i        (lr),
    .sdata_i     (sdata_i),
    .cfg_i       (cfg),
    .word_vld_o  (w_vld),
    .word_left_o (w_left),
    .word_o      (w_data)
  );

  audio_deser_out_stage #(
    .W_MAX (W_MAX),
    .W_MIN (W_MIN)
  ) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (w_vld),
    .left_i (w_left),
    .word_i (w_data),
    .cfg_i  (cfg),
    .word_o (ch_word),
    .vld_o  (ch_vld)
  );

  assign left_o      = ch_word[0];
  assign right_o     = ch_word[1];
  assign left_vld_o  = ch_vld[0];
  assign right_vld_o = ch_vld[1];
endmodule

// File: rtl/audio_deser_chk.sv
module audio_deser_chk #(
  parameter int W = 18
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         word16_i,
  input logic [W-1:0] left_o,
  input logic         left_vld_o,
  input logic [W-1:0] right_o,
  input logic         right_vld_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!left_vld_o && !right_vld_o && left_o == '0 && right_o == '0);
    end
  end

  a_r7_left_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_vld_o |=> !left_vld_o);

  a_r7_right_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    right_vld_o |=> !right_vld_o);

  a_r7_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({left_vld_o, right_vld_o}));

  a_r7_left_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !left_vld_o |-> $stable(left_o));

  a_r7_right_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !right_vld_o |-> $stable(right_o));

  a_r6_left_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_vld_o && word16_i) |-> (left_o[W-1:W-2] == {2{left_o[W-3]}}));

  a_r6_right_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (right_vld_o && word16_i) |-> (right_o[W-1:W-2] == {2{right_o[W-3]}}));
endmodule

bind audio_deser audio_deser_chk #(.W(W_MAX)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .word16_i    (word16_i),
  .left_o      (left_o),
  .left_vld_o  (left_vld_o),
  .right_o     (right_o),
  .right_vld_o (right_vld_o)
);

// File: tb/tb_audio_deser.sv
module tb_audio_deser;

  typedef struct packed {
    logic        rj;
    logic        i2s;
    logic        w16;
    logic        pin;
    logic        fall;
    logic [6:0]  bph;
    logic [17:0] lv;
    logic [17:0] rv;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 7'd18, 18'h2A5C3, 18'h15A3C}, // R3 18b exact
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 7'd32, 18'h08001, 18'h07FFE}, // R3 R6
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 7'd24, 18'h3FFFF, 18'h00001}, // R5
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 7'd32, 18'h0F00F, 18'h00FF0}, // R5 R6 gen clk
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 7'd24, 18'h0C3A5, 18'h05A3C}, // R4
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 7'd32, 18'h20001, 18'h1FFFE}, // R4 R2 fall
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 7'd20, 18'h3C0F0, 18'h03F0F}, // R3 R2 fall
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 7'd18, 18'h24924, 18'h1B6DB}, // R2 fall ignored
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 7'd20, 18'h09C71, 18'h0638E}  // R4 priority
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bclk_pin, bclk_gen, use_pin, fall, lrck, sdata, rj, i2s, w16;
  logic [17:0] left_w, right_w;
  logic        left_v, right_v;

  int n_chk = 0;
  int n_bad = 0;
  int cnt_l = 0;
  int cnt_r = 0;
  int cyc   = 0;
  logic [17:0] first_l, first_r;

  always #5 clk = ~clk;

  audio_deser dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bclk_pin_i   (bclk_pin),
    .bclk_gen_i   (bclk_gen),
    .use_pin_i    (use_pin),
    .fall_edge_i  (fall),
    .lrck_i       (lrck),
    .sdata_i      (sdata),
    .right_just_i (rj),
    .i2s_i        (i2s),
    .word16_i     (w16),
    .left_o       (left_w),
    .left_vld_o   (left_v),
    .right_o      (right_w),
    .right_vld_o  (right_v)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (left_v) begin
        if (cnt_l == 0) first_l = left_w;
        cnt_l++;
      end
      if (right_v) begin
        if (cnt_r == 0) first_r = right_w;
        cnt_r++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles exp at most 150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [17:0] got, input logic [17:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  function automatic logic [17:0] ext(input logic w, input logic [17:0] v);
    return w ? {{2{v[15]}}, v[15:0]} : v;
  endfunction

  function automatic logic idle_lvl();
    return fall & use_pin;
  endfunction

  task automatic set_bclk(input logic v);
    if (use_pin) bclk_pin = v;
    else         bclk_gen = v;
  endtask

  task automatic set_cfg(input logic r, input logic i, input logic w, input logic p, input logic f);
    rj = r; i2s = i; w16 = w; use_pin = p; fall = f;
    bclk_pin = 1'b0; bclk_gen = 1'b0;
    set_bclk(idle_lvl());
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    cnt_l = 0; cnt_r = 0; first_l = '0; first_r = '0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic drive_bit(input logic lr, input logic d);
    set_bclk(idle_lvl());
    lrck = lr; sdata = d;
    repeat (2) @(negedge clk);
    set_bclk(~idle_lvl());
    repeat (2) @(negedge clk);
  endtask

  function automatic logic pick(input int i, input int bph, input logic [17:0] v);
    int  n;
    logic junk;
    n = w16 ? 16 : 18;
    junk = (i % 2) == 0;
    if (i2s)     return (i >= 1 && i <= n) ? v[n-i] : junk;
    else if (rj) return (i >= bph - n) ? v[bph-1-i] : junk;
    else         return (i < n) ? v[n-1-i] : junk;
  endfunction

  task automatic send_half(input logic lr, input int bph, input logic [17:0] v);
    for (int i = 0; i < bph; i++) drive_bit(lr, pick(i, bph, v));
  endtask

  task automatic run_vec(input int k, input vec_t v);
    logic  lft;
    string tag;
    set_cfg(v.rj, v.i2s, v.w16, v.pin, v.fall);
    do_reset();
    lft = ~v.i2s;
    tag = v.i2s ? "R4" : (v.rj ? "R5" : "R3");
    if (v.fall) tag = {tag, "/R2"};
    if (v.w16)  tag = {tag, "/R6"};
    send_half(~lft, int'(v.bph), 18'h15555);
    send_half(lft, int'(v.bph), v.lv);
    send_half(~lft, int'(v.bph), v.rv);
    drive_bit(lft, 1'b1);
    repeat (3) @(negedge clk);
    chk($sformatf("%s R7 vec%0d left count", tag, k), 18'(cnt_l), 18'd1);
    chk($sformatf("%s R7 vec%0d right count", tag, k), 18'(cnt_r), 18'd1);
    chk($sformatf("%s vec%0d left word", tag, k), first_l, ext(v.w16, v.lv));
    chk($sformatf("%s vec%0d right word", tag, k), first_r, ext(v.w16, v.rv));
  endtask

  initial begin
    rst_n = 1'b0; lrck = 1'b0; sdata = 1'b0;
    set_cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    // R1: outputs quiet in reset
    chk("R1 left/right words", left_w | right_w, 18'd0);
    chk("R1 strobes", {16'd0, left_v, right_v}, 18'd0);

    for (int k = 0; k < NV; k++) run_vec(k, VECS[k]);

    // R5: period shorter than N gives no word
    set_cfg(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    do_reset();
    send_half(1'b0, 18, 18'h0);
    send_half(1'b1, 10, 18'h3FFFF);
    send_half(1'b0, 18, 18'h2B3C4);
    drive_bit(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R5 short period left count", 18'(cnt_l), 18'd0);
    chk("R5 right count", 18'(cnt_r), 18'd1);
    chk("R5 right word", first_r, 18'h2B3C4);

    // R8: nothing before the first LRCK change
    set_cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    do_reset();
    send_half(1'b1, 20, 18'h12345);
    chk("R8 no word before sync", 18'(cnt_l), 18'd0);
    send_half(1'b0, 18, 18'h3A5A5);
    drive_bit(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R8 right count", 18'(cnt_r), 18'd1);
    chk("R8 right word", first_r, 18'h3A5A5);

    // R9: exact strobe cycle, R7: pulse width and hold
    set_cfg(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    do_reset();
    send_half(1'b0, 4, 18'h0);
    for (int i = 0; i < 15; i++) drive_bit(1'b1, pick(i, 16, 18'h0B00D));
    set_bclk(1'b0); lrck = 1'b1; sdata = pick(15, 16, 18'h0B00D);
    repeat (2) @(negedge clk);
    set_bclk(1'b1);
    @(negedge clk);
    chk("R9 strobe one cycle after edge", {17'd0, left_v}, 18'd1);
    chk("R9 word with strobe", left_w, ext(1'b1, 18'h0B00D));
    @(negedge clk);
    chk("R7 strobe low next cycle", {17'd0, left_v}, 18'd0);
    for (int i = 0; i < 6; i++) drive_bit(1'b1, 1'b1);
    chk("R7 word held", left_w, ext(1'b1, 18'h0B00D));
    chk("R7 single left pulse", 18'(cnt_l), 18'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule